// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns 16-bit segment and offset pairs into 20-bit physical byte addresses the way a 16-bit processor does in its real addressing mode: the segment is moved four bit positions up and the offset is added, giving a 1 MB space in which many segment/offset pairs may name the same byte. It owns four 16-bit segment registers (code, data, stack, extra) loaded through a write port, and a 16-bit stack pointer that it steps itself.

A requester presents one access per cycle with a kind (instruction fetch, data, stack push, stack pop), a far flag with an explicit segment, and an offset. Near fetch and data accesses take their segment from the code or data register; far ones use the supplied segment. Stack accesses always address the stack segment at the stack pointer. The stack holds words only and grows downward, so a push steps the pointer down by two before it is used and a pop uses it before stepping it up by two. The address is registered and appears one clock after the request, together with a valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: One clock after a cycle with `req_valid` high, `addr_valid` is high and `phys_addr` holds the address of that request; after a cycle with `req_valid` low, `addr_valid` is low and `phys_addr` keeps its previous value. Segment A000h with offset 5677h gives A5677h, and so does A111h with 4567h.
- R2: A near request (`req_far`=0) of kind fetch (`req_kind`=0) uses the code segment register, and of kind data (`req_kind`=1) uses the data segment register. Segment registers are written with `seg_wr_sel` 0=code, 1=data, 2=stack, 3=extra.
- R3: A far request (`req_far`=1) of kind fetch or data uses `req_seg` as the segment, with `req_off` as the offset.
- R4: A push (`req_kind`=2) sets the stack pointer to its old value minus 2 and issues stack segment * 16 plus that new value.
- R5: A pop (`req_kind`=3) issues stack segment * 16 plus the current stack pointer and then sets the stack pointer to its old value plus 2.
- R6: Push and pop ignore `req_far`, `req_seg` and `req_off`; fetch and data requests leave the stack pointer unchanged.
- R7: The sum of shifted segment and offset is taken modulo 2^20 (FFFFh:FFFFh gives 0FFEFh).
- R8: The stack pointer wraps modulo 2^16: a push from 0000h leaves FFFEh, a pop from FFFEh leaves 0000h.
- R9: A segment register written in the same cycle as a request does not affect that request; it takes effect for the following one.
- R10: After reset, `addr_valid`, `phys_addr`, `stack_ptr` and all segment registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment register to write: 0 code, 1 data, 2 stack, 3 extra |
| seg_wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 data, 2 push, 3 pop |
| req_far | input | 1 | Use `req_seg` instead of the default segment (fetch/data only) |
| req_seg | input | 16 | Explicit segment for far requests |
| req_off | input | 16 | Offset for fetch/data requests |
| addr_valid | output | 1 | Physical address valid strobe |
| phys_addr | output | 20 | Registered physical address |
| stack_ptr | output | 16 | Current stack pointer |

## Verification
The bench goes after the two aliasing pairs, the 1 MB carry wrap, pushes and pops across the 0000h/FFFEh pointer boundary, a segment write landing in the same cycle as a request that reads it, and stack requests carrying junk far fields. A design that kept bit 20 would alias the wrap case wrongly; one that pushed before decrementing, or popped after incrementing, would be off by two words; a write-through register file would let the new segment leak into the current request; and a stack path that honoured the far flag would address outside the stack segment. Random mixes of all four kinds with concurrent register writes are checked against a bench model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_PUSH  = 2'd2,
    ACC_POP   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [SEG_W-1:0]                wr_data,
  output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_d;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));

    always_comb begin
      seg_d[g] = seg_q[g];
      if (hit) seg_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[g] <= '0;
      else        seg_q[g] <= seg_d[g];
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int SP_W = 16,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_dec
);
  localparam logic [SP_W-1:0] STEP_V = SP_W'(STEP);
  logic [SP_W-1:0] sp_d;

  assign sp_dec = sp_q - STEP_V;

  always_comb begin
    sp_d = sp_q;
    if (push)     sp_d = sp_dec;
    else if (pop) sp_d = sp_q + STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  assign seg_ext = ADDR_W'(seg) << SHIFT;
  assign off_ext = ADDR_W'(off);
  assign addr    = seg_ext + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int ADDR_W  = 20,
  parameter int NUM_SEG = 4,
  parameter int STEP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [1:0]        seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_far,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [OFF_W-1:0]  stack_ptr
);
  localparam int SEL_W = $clog2(NUM_SEG);

  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  seg_regfile #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_segs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(seg_wr_en),
    .wr_sel(SEL_W'(seg_wr_sel)), .wr_data(seg_wr_data), .seg_q(seg_q)
  );

  acc_kind_e kind;
  logic      is_push, is_pop;
  assign kind    = acc_kind_e'(req_kind);
  assign is_push = req_valid && (kind == ACC_PUSH);
  assign is_pop  = req_valid && (kind == ACC_POP);

  logic [OFF_W-1:0] sp_q, sp_dec;
  stack_ptr_unit #(.SP_W(OFF_W), .STEP(STEP)) u_sp (
    .clk(clk), .rst_n(rst_core_n), .push(is_push), .pop(is_pop),
    .sp_q(sp_q), .sp_dec(sp_dec)
  );

  seg_sel_e         dflt_sel;
  logic [SEG_W-1:0] use_seg;
  logic [OFF_W-1:0] use_off;

  always_comb begin
    dflt_sel = SEG_DATA;
    use_off  = req_off;
    unique case (kind)
      ACC_FETCH: dflt_sel = SEG_CODE;
      ACC_DATA:  dflt_sel = SEG_DATA;
      ACC_PUSH: begin dflt_sel = SEG_STACK; use_off = sp_dec; end
      ACC_POP:  begin dflt_sel = SEG_STACK; use_off = sp_q;   end
    endcase
    use_seg = seg_q[dflt_sel];
    if (req_far && !is_push && !is_pop && !(kind inside {ACC_PUSH, ACC_POP}))
      use_seg = req_seg;
  end

  logic [ADDR_W-1:0] addr_comb;
  addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
    .seg(use_seg), .off(use_off), .addr(addr_comb)
  );

  logic [ADDR_W-1:0] addr_d;
  logic              valid_d;
  always_comb begin
    valid_d = req_valid;
    addr_d  = phys_addr;
    if (req_valid) addr_d = addr_comb;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_valid <= 1'b0;
      phys_addr  <= '0;
    end else begin
      addr_valid <= valid_d;
      phys_addr  <= addr_d;
    end
  end

  assign stack_ptr = sp_q;
endmodule

// File: rtl/seg_addr_gen_checker.sv
module seg_addr_gen_checker #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_far,
  input logic [SEG_W-1:0]  req_seg,
  input logic [OFF_W-1:0]  req_off,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [OFF_W-1:0]  stack_ptr
);
  logic [ADDR_W-1:0] far_exp;
  assign far_exp = (ADDR_W'(req_seg) << SHIFT) + ADDR_W'(req_off);

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && $stable(phys_addr)));

  assert_far_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_far && !req_kind[1]) |=> (phys_addr == $past(far_exp)));

  assert_push_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |=> (stack_ptr == $past(stack_ptr) - OFF_W'(STEP)));

  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=> (stack_ptr == $past(stack_ptr) + OFF_W'(STEP)));

  assert_sp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_kind[1]) |=> $stable(stack_ptr));
endmodule

bind seg_addr_gen seg_addr_gen_checker #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W), .STEP(STEP)
) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_far(req_far), .req_seg(req_seg), .req_off(req_off),
  .addr_valid(addr_valid), .phys_addr(phys_addr), .stack_ptr(stack_ptr)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        req_far;
  logic [15:0] req_seg;
  logic [15:0] req_off;
  logic        addr_valid;
  logic [19:0] phys_addr;
  logic [15:0] stack_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
    .seg_wr_data(seg_wr_data), .req_valid(req_valid), .req_kind(req_kind),
    .req_far(req_far), .req_seg(req_seg), .req_off(req_off),
    .addr_valid(addr_valid), .phys_addr(phys_addr), .stack_ptr(stack_ptr)
  );

  int total = 0;
  int bad   = 0;
  logic [15:0] m_seg [4];
  logic [15:0] m_sp;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] sum;
    sum = {1'b0, s, 4'b0} + {5'b0, o};
    return sum[19:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [1:0] kind, input logic far,
                        input logic [15:0] sg, input logic [15:0] off,
                        input logic wen, input logic [1:0] wsel, input logic [15:0] wdat);
    logic [19:0] exp_a;
    logic [15:0] exp_sp;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_far = far; req_seg = sg; req_off = off;
    seg_wr_en = wen; seg_wr_sel = wsel; seg_wr_data = wdat;
    exp_sp = m_sp;
    case (kind)
      2'd0: exp_a = phys(far ? sg : m_seg[0], off);
      2'd1: exp_a = phys(far ? sg : m_seg[1], off);
      2'd2: begin exp_sp = m_sp - 16'd2; exp_a = phys(m_seg[2], exp_sp); end
      default: begin exp_a = phys(m_seg[2], m_sp); exp_sp = m_sp + 16'd2; end
    endcase
    @(posedge clk); #1;
    chk({tag, " valid"}, {31'b0, addr_valid}, 32'd1);
    chk({tag, " addr"}, {12'b0, phys_addr}, {12'b0, exp_a});
    chk({tag, " sp"}, {16'b0, stack_ptr}, {16'b0, exp_sp});
    m_sp = exp_sp;
    if (wen) m_seg[wsel] = wdat;
    req_valid = 1'b0; seg_wr_en = 1'b0;
  endtask

  task automatic seg_write(input logic [1:0] wsel, input logic [15:0] wdat);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = wsel; seg_wr_data = wdat;
    @(posedge clk); #1;
    seg_wr_en = 1'b0;
    m_seg[wsel] = wdat;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
    req_valid = 0; req_kind = 0; req_far = 0; req_seg = 0; req_off = 0;
    for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
    m_sp = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", {31'b0, addr_valid}, 32'd0);
    chk("R10 reset addr", {12'b0, phys_addr}, 32'd0);
    chk("R10 reset sp", {16'b0, stack_ptr}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: segment registers start at zero (near fetch / data use them)
    access("R10 code zero", 2'd0, 1'b0, 16'hBEEF, 16'h1234, 0, 0, 0);
    access("R10 data zero", 2'd1, 1'b0, 16'hBEEF, 16'h0042, 0, 0, 0);

    // R1 / R2: near data with data segment
    seg_write(2'd1, 16'hA000);
    access("R1 R2 near data A000:5677", 2'd1, 1'b0, 16'h0, 16'h5677, 0, 0, 0);
    chk("R1 alias value", {12'b0, phys_addr}, 32'hA5677);
    seg_write(2'd0, 16'h1234);
    access("R2 near fetch", 2'd0, 1'b0, 16'h0, 16'h0010, 0, 0, 0);

    // R3: far alias pair
    access("R3 far A111:4567", 2'd1, 1'b1, 16'hA111, 16'h4567, 0, 0, 0);
    chk("R1 R3 alias value", {12'b0, phys_addr}, 32'hA5677);
    access("R3 far fetch", 2'd0, 1'b1, 16'h0F00, 16'h00FF, 0, 0, 0);

    // R7: carry out of bit 19 discarded
    access("R7 wrap", 2'd1, 1'b1, 16'hFFFF, 16'hFFFF, 0, 0, 0);
    chk("R7 wrap value", {12'b0, phys_addr}, 32'h0FFEF);

    // R1: idle cycle holds address, no strobe
    held = phys_addr;
    @(posedge clk); #1;
    chk("R1 idle valid", {31'b0, addr_valid}, 32'd0);
    chk("R1 idle hold", {12'b0, phys_addr}, {12'b0, held});

    // R4 / R5 / R8: stack across zero boundary
    seg_write(2'd2, 16'h3000);
    access("R4 R8 push from 0", 2'd2, 1'b0, 16'h0, 16'h0, 0, 0, 0);
    chk("R8 sp wrapped", {16'b0, stack_ptr}, 32'h0000FFFE);
    access("R6 push ignores far", 2'd2, 1'b1, 16'h7777, 16'h5555, 0, 0, 0);
    access("R5 pop", 2'd3, 1'b1, 16'h1111, 16'h2222, 0, 0, 0);
    access("R5 R8 pop to 0", 2'd3, 1'b0, 16'h0, 16'h0, 0, 0, 0);
    chk("R8 sp back to 0", {16'b0, stack_ptr}, 32'h0);
    access("R6 data keeps sp", 2'd1, 1'b0, 16'h0, 16'h0001, 0, 0, 0);

    // R9: same-cycle segment write affects only later requests
    access("R9 fetch with concurrent CS write", 2'd0, 1'b0, 16'h0, 16'h0100, 1'b1, 2'd0, 16'h5000);
    chk("R9 old code seg used", {12'b0, phys_addr}, 32'h12440);
    access("R9 fetch after write", 2'd0, 1'b0, 16'h0, 16'h0100, 0, 0, 0);
    chk("R9 new code seg used", {12'b0, phys_addr}, 32'h50100);
    access("R9 push with concurrent SS write", 2'd2, 1'b0, 16'h0, 16'h0, 1'b1, 2'd2, 16'h9000);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] k;
      k = 2'($urandom % 4);
      access($sformatf("R1 R2 R3 R4 R5 R9 random %0d", i), k, 1'($urandom), 16'($urandom),
             16'($urandom), 1'($urandom % 3 == 0), 2'($urandom), 16'($urandom));
      if ($urandom % 5 == 0) begin
        held = phys_addr;
        @(posedge clk); #1;
        chk("R1 random idle", {11'b0, addr_valid, phys_addr}, {12'b0, held});
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule